// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block steps an external converter core around a set of input channels while the converter runs continuously. A channel mask chooses which inputs take part. The block visits the enabled channels in rising index order and wraps from the highest back to the lowest. Each time it selects a new channel it pulses a filter-reset output. It then discards converter results until a programmable number of them has arrived, so that the digital filter has settled. The next result is the first valid one. The block stores it, drives an active-low ready flag, and moves on to the next enabled channel. The host reads the stored word while the next channel settles.

The converter's modulator and filter lie outside the block. They appear here as a one-cycle result strobe that comes with a data word. A tagging control can add a status byte below the data word, which lets the host tell which channel each result belongs to. If only one channel is enabled, the sequencer stays on that channel, and after one settling period every result is valid.

Top module: `conv_sequencer`

## Requirements
- R1: While `run` is high and the mask is nonzero, the sequencer first selects the lowest enabled channel. After each valid result it moves to the next enabled channel above the current one, and wraps from the highest enabled channel to the lowest. `cur_chan` shows the channel in use.
- R2: Each channel selection raises `filt_rst` for exactly one cycle. During that cycle `cur_chan` already holds the newly selected channel.
- R3: After a selection, the first `settle_len`−1 result strobes are discarded and the `settle_len`-th strobe is captured. A `settle_len` of 0 acts as 1.
- R4: `rdy_n` goes low in the cycle after a capture. It stays low until `rd_done` is seen, unless the sequencer goes idle.
- R5: A result strobe in the cycle where `filt_rst` is high is ignored. It does not count toward settling and `rdy_n` does not fall because of it.
- R6: With `tag_en` high, the stored word is {data[23:0], 5'b0, channel[2:0]}, with the channel index in bits 2:0. With `tag_en` low, it is {8'h00, data[23:0]}.
- R7: With a single channel enabled, every strobe after the settling period is captured, and no further `filt_rst` pulse occurs.
- R8: With `run` low, or with a zero mask, the block idles. `rdy_n` is high, no `filt_rst` pulses occur and strobes are ignored. Reset leaves `rdy_n` high, `filt_rst` low and the stored word zero.
- R9: A mask change while a channel is settling does not interrupt that channel. The new mask is used when the next channel is chosen, after that channel's valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Continuous sequencing enable |
| chan_mask | input | NUM_CH | One enable bit per channel |
| tag_en | input | 1 | Add the channel status byte to each result |
| settle_len | input | CNT_W | Number of result strobes per settling period |
| conv_strobe | input | 1 | Converter result available this cycle |
| conv_data | input | DATA_W | Converter result word |
| rd_done | input | 1 | Host finished reading the stored word |
| filt_rst | output | 1 | One-cycle filter/modulator reset on channel selection |
| cur_chan | output | CH_W | Channel currently being converted |
| rdy_n | output | 1 | Active-low result-ready flag |
| res_word | output | DATA_W+STAT_W | Stored result, tagged or zero-padded |

## Verification
The bench builds the block with six channels and a 4-bit settling counter. Six channels force the wrap from index 5 back to 0 through modulo arithmetic that is not a power of two. The narrow counter keeps settling periods short enough to cover many channel switches, a zero-length setting and the single-channel streaming case in a short run. The data and status widths keep their defaults, so the channel tag lies in the low three bits of a 32-bit word.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SWITCH = 2'd1,
      SQ_CONV   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/seq_next_chan.sv
// Finds the first enabled channel at or after start, wrapping around.
module seq_next_chan #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   start,
   output logic [CH_W-1:0]   nxt,
   output logic              found
);

   always_comb begin
      nxt   = '0;
      found = 1'b0;
      // scan farthest first so the nearest hit is written last
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         int idx;
         idx = (int'(start) + k) % NUM_CH;
         if (mask[idx]) begin
            nxt   = idx[CH_W-1:0];
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/seq_settle_cnt.sv
// Counts result strobes since the last filter reset; flags settled ones.
module seq_settle_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             stb,
   input  logic [CNT_W-1:0] len,
   output logic             take
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] len_eff;
   logic [CNT_W:0]   cnt_nxt;

   assign len_eff = (len == '0) ? CNT_W'(1) : len;
   assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign take    = stb && (cnt_nxt >= {1'b0, len_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (stb && (cnt_q != '1)) begin
         cnt_q <= cnt_nxt[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/seq_result_reg.sv
// Holds the captured word and the active-low ready flag.
module seq_result_reg #(
   parameter int DATA_W = 24,
   parameter int STAT_W = 8,
   parameter int CH_W   = 3,
   localparam int RES_W = DATA_W + STAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              force_hi,
   input  logic              rd_done,
   input  logic              tag_en,
   input  logic [DATA_W-1:0] data,
   input  logic [CH_W-1:0]   chan,
   output logic              rdy_n,
   output logic [RES_W-1:0]  word
);

   logic [STAT_W-1:0] status;

   generate
      if (STAT_W > CH_W) begin : g_pad
         assign status = {{(STAT_W - CH_W){1'b0}}, chan};
      end else begin : g_exact
         assign status = chan;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (capture) begin
         word <= tag_en ? {data, status} : {{STAT_W{1'b0}}, data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n <= 1'b1;
      end else if (force_hi) begin
         rdy_n <= 1'b1;
      end else if (capture) begin
         rdy_n <= 1'b0;
      end else if (rd_done) begin
         rdy_n <= 1'b1;
      end
   end

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 24,
   parameter int STAT_W = 8,
   parameter int CNT_W  = 8,
   localparam int CH_W  = $clog2(NUM_CH),
   localparam int RES_W = DATA_W + STAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [NUM_CH-1:0] chan_mask,
   input  logic              tag_en,
   input  logic [CNT_W-1:0]  settle_len,
   input  logic              conv_strobe,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              rd_done,
   output logic              filt_rst,
   output logic [CH_W-1:0]   cur_chan,
   output logic              rdy_n,
   output logic [RES_W-1:0]  res_word
);

   import seq_pkg::*;

   if (NUM_CH < 2) begin : g_chk_ch
      $error("conv_sequencer: NUM_CH must be at least 2");
   end
   if (STAT_W < CH_W) begin : g_chk_stat
      $error("conv_sequencer: STAT_W too narrow for channel index");
   end
   if (DATA_W < 1 || CNT_W < 1) begin : g_chk_w
      $error("conv_sequencer: DATA_W and CNT_W must be positive");
   end

   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   seq_state_e      state_q, state_d;
   logic [CH_W-1:0] chan_q, chan_d;
   logic [CH_W-1:0] start_idx;
   logic [CH_W-1:0] nxt_chan;
   logic            nxt_found;
   logic            take;
   logic            capture;
   logic            cnt_stb;

   always_comb begin
      if (state_q == SQ_IDLE || chan_q == LAST_CH) start_idx = '0;
      else                                        start_idx = chan_q + CH_W'(1);
   end

   seq_next_chan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .mask  (chan_mask),
      .start (start_idx),
      .nxt   (nxt_chan),
      .found (nxt_found)
   );

   assign cnt_stb = conv_strobe && (state_q == SQ_CONV);

   seq_settle_cnt #(.CNT_W(CNT_W)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == SQ_SWITCH),
      .stb   (cnt_stb),
      .len   (settle_len),
      .take  (take)
   );

   assign capture = take && run && nxt_found;

   always_comb begin
      state_d = state_q;
      chan_d  = chan_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (run && nxt_found) begin
               state_d = SQ_SWITCH;
               chan_d  = nxt_chan;
            end
         end
         SQ_SWITCH: begin
            state_d = run ? SQ_CONV : SQ_IDLE;
         end
         SQ_CONV: begin
            if (!run) begin
               state_d = SQ_IDLE;
            end else if (take) begin
               if (!nxt_found) begin
                  state_d = SQ_IDLE;
               end else if (nxt_chan != chan_q) begin
                  state_d = SQ_SWITCH;
                  chan_d  = nxt_chan;
               end
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         chan_q  <= '0;
      end else begin
         state_q <= state_d;
         chan_q  <= chan_d;
      end
   end

   seq_result_reg #(.DATA_W(DATA_W), .STAT_W(STAT_W), .CH_W(CH_W)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .force_hi (state_d == SQ_IDLE),
      .rd_done  (rd_done),
      .tag_en   (tag_en),
      .data     (conv_data),
      .chan     (chan_q),
      .rdy_n    (rdy_n),
      .word     (res_word)
   );

   assign filt_rst = (state_q == SQ_SWITCH);
   assign cur_chan = chan_q;

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3,
   parameter int DATA_W = 24,
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic [NUM_CH-1:0] chan_mask,
   input logic              tag_en,
   input logic              rd_done,
   input logic              filt_rst,
   input logic [CH_W-1:0]   cur_chan,
   input logic              rdy_n,
   input logic [STAT_W-1:0] res_lo,
   input logic [STAT_W-1:0] res_hi
);

   logic [NUM_CH-1:0] mask_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_d <= '0;
      else        mask_d <= chan_mask;
   end

   p_sel_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      filt_rst |-> mask_d[cur_chan]);

   p_rst_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      filt_rst |=> !filt_rst);

   p_rdy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !rd_done && run && (chan_mask != '0)) |=> !rdy_n);

   p_rdy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_n) |-> $past(rd_done || !run || (chan_mask == '0)));

   p_no_early_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      filt_rst |=> !$fell(rdy_n));

   p_tag_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rdy_n) && $past(tag_en)) |-> (res_lo == STAT_W'($past(cur_chan))));

   p_untag_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rdy_n) && !$past(tag_en)) |-> (res_hi == '0));

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (rdy_n && !filt_rst));

endmodule

bind conv_sequencer seq_checker #(
   .NUM_CH (NUM_CH),
   .CH_W   (CH_W),
   .DATA_W (DATA_W),
   .STAT_W (STAT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .chan_mask (chan_mask),
   .tag_en    (tag_en),
   .rd_done   (rd_done),
   .filt_rst  (filt_rst),
   .cur_chan  (cur_chan),
   .rdy_n     (rdy_n),
   .res_lo    (res_word[STAT_W-1:0]),
   .res_hi    (res_word[DATA_W+STAT_W-1:DATA_W])
);

// File: tb/conv_sequencer_test.sv
`timescale 1ns/1ps
module conv_sequencer_test;

   localparam int NCH = 6;
   localparam int DW  = 24;
   localparam int SW  = 8;
   localparam int CW  = 4;
   localparam int HW  = 3;
   localparam int RW  = DW + SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic [NCH-1:0] chan_mask = '0;
   logic          tag_en = 1'b0;
   logic [CW-1:0] settle_len = '0;
   logic          conv_strobe = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic          rd_done = 1'b0;
   logic          filt_rst;
   logic [HW-1:0] cur_chan;
   logic          rdy_n;
   logic [RW-1:0] res_word;

   always #2.5 clk = ~clk;

   conv_sequencer #(.NUM_CH(NCH), .DATA_W(DW), .STAT_W(SW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .chan_mask(chan_mask),
      .tag_en(tag_en), .settle_len(settle_len), .conv_strobe(conv_strobe),
      .conv_data(conv_data), .rd_done(rd_done), .filt_rst(filt_rst),
      .cur_chan(cur_chan), .rdy_n(rdy_n), .res_word(res_word)
   );

   int errors = 0;
   int checks = 0;
   logic [RW-1:0] exp_q[$];
   int fr_cnt = 0;
   bit auto_ack = 1'b1;
   int ack_req = 0;
   int ack_done = 0;

   // reference model state
   bit m_act = 1'b0;
   int m_chan = 0;
   int m_cnt = 0;
   int m_resets = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic int find_from(input int start, input logic [NCH-1:0] m);
      for (int k = 0; k < NCH; k++) begin
         int idx;
         idx = (start + k) % NCH;
         if (m[idx]) return idx;
      end
      return -1;
   endfunction

   // monitor: pop expected items on each ready fall
   initial begin
      bit prev = 1'b1;
      forever begin
         @(negedge clk);
         rd_done = 1'b0;
         if (!rst_n) begin
            prev = 1'b1;
         end else begin
            if (filt_rst) fr_cnt++;
            if (prev && !rdy_n) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R3 unexpected result", res_word, 0);
               end else begin
                  logic [RW-1:0] e;
                  e = exp_q.pop_front();
                  check(res_word == e, "R6 result word", res_word, e);
               end
               if (auto_ack) rd_done = 1'b1;
            end
            if (ack_req != ack_done) begin
               rd_done = 1'b1;
               ack_done = ack_req;
            end
            prev = rdy_n;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog (all)", 0, 1);
      summary();
   end

   task automatic model_step(input logic [DW-1:0] d);
      int len_eff;
      int nx;
      if (!m_act) return;
      m_cnt++;
      len_eff = (settle_len == 0) ? 1 : int'(settle_len);
      if (m_cnt >= len_eff) begin
         nx = find_from((m_chan + 1) % NCH, chan_mask);
         if (nx < 0) begin
            m_act = 1'b0;
         end else begin
            exp_q.push_back(tag_en ? {d, 5'b0, 3'(m_chan)} : {8'h00, d});
            if (nx != m_chan) begin
               m_chan = nx;
               m_cnt = 0;
               m_resets++;
            end
         end
      end
   endtask

   task automatic set_cfg(input bit r, input logic [NCH-1:0] m, input bit t, input logic [CW-1:0] len);
      @(negedge clk);
      run = r; chan_mask = m; tag_en = t; settle_len = len;
      if (!r) m_act = 1'b0;
      else if (!m_act && m != 0) begin
         m_act = 1'b1;
         m_chan = find_from(0, m);
         m_cnt = 0;
         m_resets++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic strobe(input logic [DW-1:0] d);
      @(negedge clk);
      conv_strobe = 1'b1;
      conv_data = d;
      model_step(d);
      @(negedge clk);
      conv_strobe = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int fr_snap;
      repeat (4) @(negedge clk);
      check(rdy_n == 1'b1, "R8 reset rdy_n", rdy_n, 1);
      check(filt_rst == 1'b0, "R8 reset filt_rst", filt_rst, 0);
      check(res_word == '0, "R8 reset word", res_word, 0);
      rst_n = 1'b1;

      // R8: running with an empty mask stays idle
      set_cfg(1'b1, 6'b000000, 1'b1, 4'd4);
      strobe(24'h111111);
      repeat (5) @(negedge clk);
      check(fr_cnt == 0, "R8 no filt_rst on empty mask", fr_cnt, 0);
      check(rdy_n == 1'b1, "R8 idle rdy_n", rdy_n, 1);

      // R1/R3/R6: channels 0,2,5 tagged, settle 4
      set_cfg(1'b1, 6'b100101, 1'b1, 4'd4);
      check(cur_chan == 3'd0, "R1 starts at lowest", cur_chan, 0);
      for (int i = 0; i < 24; i++) strobe(24'hA00000 + 24'(i));
      check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
      check(fr_cnt == m_resets, "R2 filt_rst count", fr_cnt, m_resets);
      check(int'(cur_chan) == m_chan, "R1 wrap channel", cur_chan, m_chan);

      // R5: strobe held during the filter-reset cycle is ignored
      for (int i = 0; i < 3; i++) strobe(24'hB00000 + 24'(i));
      @(negedge clk);
      conv_strobe = 1'b1; conv_data = 24'hB0000F; model_step(24'hB0000F);
      @(negedge clk);
      check(filt_rst == 1'b1, "R2 filt_rst after capture", filt_rst, 1);
      check(int'(cur_chan) == m_chan, "R2 new chan during reset", cur_chan, m_chan);
      conv_data = 24'hBEEEEE;
      @(negedge clk);
      conv_strobe = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3; i++) strobe(24'hB10000 + 24'(i));
      check(rdy_n == 1'b1 && exp_q.size() == 0, "R5 no early result", rdy_n, 1);
      strobe(24'hB1FFFF);
      check(exp_q.size() == 0, "R5 result after full settle", exp_q.size(), 0);

      // R9: mask change mid-settle applies after current result
      strobe(24'hC00001);
      strobe(24'hC00002);
      @(negedge clk);
      chan_mask = 6'b000110;
      strobe(24'hC00003);
      strobe(24'hC00004);
      check(int'(cur_chan) == m_chan, "R9 channel after mask change", cur_chan, m_chan);
      for (int i = 0; i < 8; i++) strobe(24'hC10000 + 24'(i));
      check(exp_q.size() == 0, "R9 results drained", exp_q.size(), 0);

      // R3/R6: zero settle acts as one, untagged
      set_cfg(1'b1, 6'b110011, 1'b0, 4'd0);
      for (int i = 0; i < 10; i++) strobe(24'hD00000 + 24'(i));
      check(fr_cnt == m_resets, "R3 switch every strobe", fr_cnt, m_resets);

      // R7: single channel streams without further resets
      set_cfg(1'b1, 6'b001000, 1'b1, 4'd3);
      for (int i = 0; i < 4; i++) strobe(24'hE00000 + 24'(i));
      check(cur_chan == 3'd3, "R7 single channel selected", cur_chan, 3);
      fr_snap = fr_cnt;
      for (int i = 0; i < 5; i++) strobe(24'hE10000 + 24'(i));
      check(fr_cnt == fr_snap, "R7 no resets while streaming", fr_cnt, fr_snap);
      check(exp_q.size() == 0, "R7 every strobe captured", exp_q.size(), 0);

      // R4: ready held until read
      auto_ack = 1'b0;
      strobe(24'hF00001);
      repeat (10) @(negedge clk);
      check(rdy_n == 1'b0, "R4 ready held", rdy_n, 0);
      ack_req++;
      repeat (3) @(negedge clk);
      check(rdy_n == 1'b1, "R4 ready released by read", rdy_n, 1);
      auto_ack = 1'b1;

      // R8: run low idles
      set_cfg(1'b0, 6'b001000, 1'b1, 4'd3);
      fr_snap = fr_cnt;
      for (int i = 0; i < 3; i++) strobe(24'h900000 + 24'(i));
      check(fr_cnt == fr_snap, "R8 no resets when stopped", fr_cnt, fr_snap);
      check(rdy_n == 1'b1, "R8 stopped rdy_n", rdy_n, 1);

      // R1: wrap 5 -> 0 on six channels
      set_cfg(1'b1, 6'b100001, 1'b1, 4'd2);
      for (int i = 0; i < 8; i++) strobe(24'h800000 + 24'(i));
      check(exp_q.size() == 0, "R1 wrap results drained", exp_q.size(), 0);
      check(fr_cnt == m_resets, "R1 final reset count", fr_cnt, m_resets);

      repeat (5) @(negedge clk);
      summary();
   end

endmodule